// File: doc/BRIEF.md
# Processor Reset Supervisor with Dual-Period Watchdog

This block produces a reset for a processor, with an active-low output and an active-high output. Two conditions cause a reset. The first is a digital low-supply flag. It stands in for the output of an analog comparator, and it forces reset for as long as it is high. The second is a watchdog that expects the processor to toggle a service pin. Each reset, whatever its cause, lasts a fixed number of cycles after its trigger goes away. This gives the supply and the processor time to settle.

The watchdog has two timeout lengths, both set as parameters in clock cycles. Whenever a reset ends, the processor first gets the long timeout as a grace window. The short timeout applies only after the processor has produced its first service edge. A mode input can hold the watchdog on the long timeout permanently. A disable input switches off watchdog-generated resets. It models a service pin left floating or tied to mid-supply. The service pin is asynchronous, so it passes through a synchroniser chain before its edges are detected.

Top module: `rsup_top`

## Requirements
- R1: While `line_low` is 1, `cpu_rst_n` is 0 in the same cycle, with no register delay.
- R2: After `line_low` returns to 0, `cpu_rst_n` stays 0 for exactly HOLD_CYC further cycles, counted from the first cycle in which `line_low` is 0.
- R3: `cpu_rst` is always the logical inverse of `cpu_rst_n`.
- R4: When `wd_long_sel` is 1, the service timeout is always LONG_CYC, including after the first service edge.
- R5: Every time reset ends, the watchdog restarts with the long timeout. If no service edge and no low-line event occur, `cpu_rst_n` falls after exactly LONG_CYC high cycles.
- R6: With `wd_long_sel` at 0, the first service edge after reset release switches the watchdog to SHORT_CYC. A level change of `wd_in` in cycle k after release, where cycle 0 is the first high cycle, gives a reset after k + SYNC_STAGES + 1 + SHORT_CYC high cycles if no other edge follows.
- R7: Both a rising and a falling change of `wd_in` restart the timeout count.
- R8: A reset caused by the watchdog keeps `cpu_rst_n` at 0 for exactly HOLD_CYC cycles.
- R9: While `wd_disable` is 1, the watchdog causes no reset. The counter stays cleared, so after `wd_disable` returns to 0 a full timeout must pass before the next watchdog reset.
- R10: A low-line event during a watchdog reset extends that reset until HOLD_CYC cycles after `line_low` returns to 0.
- R11: While `rst_n` is 0, `cpu_rst_n` is 0 and `cpu_rst` is 1. After `rst_n` is released, reset is held for HOLD_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| line_low | input | 1 | Digital low-supply flag, 1 = supply below threshold |
| wd_in | input | 1 | Watchdog service pin, asynchronous, serviced by toggling |
| wd_disable | input | 1 | 1 = watchdog generates no resets |
| wd_long_sel | input | 1 | 1 = watchdog always uses the long timeout |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_rst | output | 1 | Processor reset, active high |

## Verification
The bench builds the block with HOLD_CYC = 8, SHORT_CYC = 20, LONG_CYC = 60 and SYNC_STAGES = 2. At these values every timeout completes within a few dozen cycles. Every reset pulse and every gap between pulses can therefore be measured to the exact cycle against the formulas in R2, R5, R6 and R8. This includes the synchroniser latency term and the extension of a watchdog reset by an overlapping low-line event. The long timeout is three times the short one, so a missed switch from long to short, or the reverse, shows up as a large error in run length.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
   // Watchdog phase: grace uses the long timeout, armed uses the selected one
   typedef enum logic {
      PH_GRACE = 1'b0,
      PH_ARMED = 1'b1
   } wd_phase_e;
endpackage

// File: rtl/rsup_edge_sync.sv
module rsup_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_o
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   // Any level change of the synchronised pin counts as service
   assign edge_o = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/rsup_hold_timer.sv
module rsup_hold_timer #(
   parameter int HOLD_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic busy
);
   localparam int HW = $clog2(HOLD_CYC + 1);
   localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYC);

   logic [HW-1:0] cnt;

   // Loaded while the trigger is present, counts down afterwards;
   // the reset value gives a power-on hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= HOLD_LD;
      else if (trig)      cnt <= HOLD_LD;
      else if (cnt != '0) cnt <= cnt - HW'(1);
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog
   import rsup_pkg::*;
#(
   parameter int SHORT_CYC = 20,
   parameter int LONG_CYC  = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic dis,
   input  logic long_sel,
   input  logic kick,
   output logic fire
);
   localparam int CW = $clog2(LONG_CYC + 1);
   localparam logic [CW-1:0] LIM_LONG  = CW'(LONG_CYC - 1);
   localparam logic [CW-1:0] LIM_SHORT = CW'(SHORT_CYC - 1);

   wd_phase_e     phase;
   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   assign limit = (phase == PH_GRACE || long_sel) ? LIM_LONG : LIM_SHORT;
   assign fire  = !clr && !dis && !kick && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= PH_GRACE;
      end else if (clr) begin
         cnt   <= '0;
         phase <= PH_GRACE;
      end else if (dis) begin
         cnt   <= '0;
      end else if (kick) begin
         cnt   <= '0;
         phase <= PH_ARMED;
      end else if (fire) begin
         cnt   <= '0;
      end else begin
         cnt   <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/rsup_top.sv
module rsup_top #(
   parameter int HOLD_CYC    = 2_500_000,
   parameter int SHORT_CYC   = 5_000_000,
   parameter int LONG_CYC    = 80_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_low,
   input  logic wd_in,
   input  logic wd_disable,
   input  logic wd_long_sel,
   output logic cpu_rst_n,
   output logic cpu_rst
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rsup_top: SYNC_STAGES must be at least 2");
      end
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("rsup_top: HOLD_CYC must be at least 2");
      end
      if (SHORT_CYC < 2) begin : g_bad_short
         $error("rsup_top: SHORT_CYC must be at least 2");
      end
      if (LONG_CYC < SHORT_CYC) begin : g_bad_long
         $error("rsup_top: LONG_CYC must not be below SHORT_CYC");
      end
   endgenerate

   logic kick;
   logic wd_fire;
   logic hold_busy;
   logic rst_act;

   rsup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (wd_in),
      .edge_o (kick)
   );

   rsup_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (line_low | wd_fire),
      .busy  (hold_busy)
   );

   rsup_watchdog #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_wd (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rst_act),
      .dis      (wd_disable),
      .long_sel (wd_long_sel),
      .kick     (kick),
      .fire     (wd_fire)
   );

   assign rst_act   = line_low | hold_busy;
   assign cpu_rst_n = !rst_act;
   assign cpu_rst   = rst_act;
endmodule

// File: rtl/rsup_top_chk.sv
module rsup_top_chk (
   input logic clk,
   input logic rst_n,
   input logic line_low,
   input logic wd_disable,
   input logic cpu_rst_n
);
   // R1
   line_forces_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_low |-> !cpu_rst_n);

   // R2
   line_recover_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_low) |-> !cpu_rst_n);

   // R2
   release_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst_n) |-> (!line_low && !$past(line_low)));

   // R8
   min_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_rst_n) |=> !cpu_rst_n);

   // R9
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rst_n && wd_disable && !line_low) |=> (cpu_rst_n || line_low));

   // R5
   grace_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst_n) |=> (cpu_rst_n || line_low));
endmodule

bind rsup_top rsup_top_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_low   (line_low),
   .wd_disable (wd_disable),
   .cpu_rst_n  (cpu_rst_n)
);

// File: tb/rsup_top_test.sv
`timescale 1ns/1ps
module rsup_top_test;
   localparam int HOLD  = 8;
   localparam int SHORT = 20;
   localparam int LONG  = 60;
   localparam int SYNC  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_low = 1'b0;
   logic wd_in = 1'b0;
   logic wd_disable = 1'b0;
   logic wd_long_sel = 1'b0;
   logic cpu_rst_n;
   logic cpu_rst;

   always #10 clk = ~clk;

   rsup_top #(.HOLD_CYC(HOLD), .SHORT_CYC(SHORT), .LONG_CYC(LONG),
              .SYNC_STAGES(SYNC)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_low    (line_low),
      .wd_in       (wd_in),
      .wd_disable  (wd_disable),
      .wd_long_sel (wd_long_sel),
      .cpu_rst_n   (cpu_rst_n),
      .cpu_rst     (cpu_rst)
   );

   typedef struct {
      logic  lvl;
      int    len;
      string req;
   } run_t;

   run_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   logic mon_on = 1'b0;
   logic started = 1'b0;
   logic cur_lvl;
   int   run_len;
   run_t got;

   task automatic expect_run(input logic lvl, input int len, input string req);
      run_t it;
      it.lvl = lvl;
      it.len = len;
      it.req = req;
      exp_q.push_back(it);
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wait_release();
      @(posedge cpu_rst_n);
      #2;
   endtask

   // Monitor: measures each run of the reset level and compares it
   always @(negedge clk) begin
      if (mon_on) begin
         n_chk++;
         if (cpu_rst !== !cpu_rst_n) begin
            n_bad++;
            $display("FAIL R3: cpu_rst=%b expected %b", cpu_rst, !cpu_rst_n);
         end
         if (!started) begin
            started = 1'b1;
            cur_lvl = cpu_rst_n;
            run_len = 1;
         end else if (cpu_rst_n === cur_lvl) begin
            run_len++;
         end else begin
            n_chk++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL unexpected: run level %b length %0d, expected none",
                        cur_lvl, run_len);
            end else begin
               got = exp_q.pop_front();
               if (got.lvl !== cur_lvl || got.len != run_len) begin
                  n_bad++;
                  $display("FAIL %s: run level %b length %0d, expected level %b length %0d",
                           got.req, cur_lvl, run_len, got.lvl, got.len);
               end
            end
            cur_lvl = cpu_rst_n;
            run_len = 1;
         end
      end
   end

   // Watchdog for the bench itself
   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL timeout: bench hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R11: outputs while the block is held in reset
      repeat (3) @(negedge clk);
      n_chk++;
      if (cpu_rst_n !== 1'b0 || cpu_rst !== 1'b1) begin
         n_bad++;
         $display("FAIL R11: rst_n=%b rst=%b, expected 0 1", cpu_rst_n, cpu_rst);
      end
      step();
      rst_n  = 1'b1;
      mon_on = 1'b1;
      // R11 power-on hold, then R5 grace timeout, then R8 pulse
      expect_run(1'b0, HOLD, "R11");
      expect_run(1'b1, LONG, "R5");
      expect_run(1'b0, HOLD, "R8");
      wait_release();
      wait_release();

      // R1 immediate assertion, R2 hold after recovery
      expect_run(1'b1, 4, "R1");
      expect_run(1'b0, 6 + HOLD, "R2");
      repeat (4) step();
      line_low = 1'b1;
      repeat (6) step();
      line_low = 1'b0;
      wait_release();

      // R6: a single edge at k=5 switches to the short timeout
      expect_run(1'b1, 5 + SYNC + 1 + SHORT, "R6");
      expect_run(1'b0, HOLD, "R8");
      repeat (5) step();
      wd_in = ~wd_in;
      wait_release();

      // R7: rising and falling edges every 10 cycles keep it alive
      expect_run(1'b1, 100 + SYNC + 1 + SHORT, "R7");
      expect_run(1'b0, HOLD, "R8");
      for (int i = 0; i < 10; i++) begin
         repeat (10) step();
         wd_in = ~wd_in;
      end
      @(negedge cpu_rst_n);
      #2;
      wd_long_sel = 1'b1;
      wait_release();

      // R4: long timeout stays in force after the first edge
      expect_run(1'b1, 10 + SYNC + 1 + LONG, "R4");
      expect_run(1'b0, HOLD, "R8");
      repeat (10) step();
      wd_in = ~wd_in;
      @(negedge cpu_rst_n);
      #2;
      wd_long_sel = 1'b0;
      wait_release();

      // R10: low-line during a watchdog reset extends it
      expect_run(1'b1, LONG, "R5");
      expect_run(1'b0, 13 + HOLD, "R10");
      @(negedge cpu_rst_n);
      repeat (3) step();
      line_low = 1'b1;
      repeat (10) step();
      line_low = 1'b0;
      wait_release();

      // R9: disable suppresses the watchdog, full timeout after re-enable
      expect_run(1'b1, 3 * LONG + LONG, "R9");
      expect_run(1'b0, HOLD, "R8");
      wd_disable = 1'b1;
      repeat (3 * LONG) step();
      wd_disable = 1'b0;
      wait_release();

      repeat (20) step();
      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R5: %0d expected runs never seen, expected 0", exp_q.size());
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule